// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the serial control port of a data converter. A host frames each access with an active-low select and clocks sixteen bits in, most significant bit first. The first byte holds a read/write flag, three reserved bits and a four-bit register address. The second byte holds the write data. All serial inputs pass through synchronisers into the block's core clock, which must run well above the serial clock. Edges of the serial clock are found by sampling it.

A write is staged while the frame is being shifted in. It is committed to the register file only when the select is released, and only if exactly sixteen rising serial edges were seen. A read returns the addressed register on the serial output during the second byte. The output changes after each falling serial edge, so the host can sample it on the following rising edge. Outside a frame the output driver is disabled through a separate enable pin for the pad buffer.

Three registers are implemented. Address 0 is the device control byte, which is decoded into mode and configuration outputs for downstream logic. Addresses 1 and 2 hold the user test pattern bytes. The other addresses in the 16-entry address space read as zero and discard writes.

Top module: `cfgspi_slave`

## Requirements
- R1: After reset every register reads 0x00, every decoded output is 0, and the serial output enable is low.
- R2: A frame is sampled on rising serial edges, MSB first: bit 15 is the read flag (1 = read, 0 = write), bits 14:12 are reserved and have no effect, bits 11:8 are the address and bits 7:0 are the data.
- R3: A write reaches the addressed register only when the select is released; while the select stays low after the sixteenth edge, the register keeps its old value.
- R4: A frame with fewer or more than sixteen rising serial edges before release writes nothing.
- R5: A read frame changes no register, whatever its data byte holds.
- R6: In a read, the register named in the first byte appears on the serial output MSB first. Bit 7 is valid before rising edge 9 and bit 0 before rising edge 16, and each bit changes after the preceding falling edge.
- R7: The output enable is high only while the select is asserted, and the serial output is 0 throughout the first byte and throughout the second byte of a write.
- R8: Addresses 3 to 15 read 0x00, and writes to them are discarded.
- R9: Register 0 drives op_mode from bits 7:6, single_lane from bit 5, dcs_en from bit 4, twos_comp from bit 3, aux_ctl from bit 2, and ctrl_rsvd from bits 1:0.
- R10: Registers 1 and 2 appear unchanged on pattern_a and pattern_b.
- R11: Frames sent back to back with a short deselected gap are each handled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for the serial data pad driver |
| op_mode_o | output | 2 | Operating mode field of register 0 |
| single_lane_o | output | 1 | Lane configuration bit of register 0 |
| dcs_en_o | output | 1 | Duty-cycle stabiliser enable of register 0 |
| twos_comp_o | output | 1 | Output number format bit of register 0 |
| aux_ctl_o | output | 1 | Further control flag of register 0 |
| ctrl_rsvd_o | output | 2 | Reserved bits of register 0 |
| pattern_a_o | output | 8 | User test pattern register 1 |
| pattern_b_o | output | 8 | User test pattern register 2 |

## Verification
Errors in the bit counter or the staged shift register show up as a wrong value on the decoded outputs about ten core cycles after release. A missed or extra edge count appears either as a write that should have been dropped or as one that never lands. A read-shifter that is out of step shows a byte shifted by one position within a single frame, and a stale shifter shows non-zero bits during the first byte of the next frame. If the commit timing is wrong, the register changes while the select is still held low, and the check made during the hold catches it.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

    parameter int ADDR_W    = 4;
    parameter int DATA_W    = 8;
    parameter int FRAME_LEN = 16;
    parameter int IMPL_REGS = 3;
    parameter int SYNC_LEN  = 2;

    localparam int RSVD_W   = FRAME_LEN - DATA_W - ADDR_W - 1;

    // register 0 field positions, decoded by the datapath downstream
    localparam int MODE_LSB = 6;
    localparam int LANE_BIT = 5;
    localparam int DCS_BIT  = 4;
    localparam int FMT_BIT  = 3;
    localparam int AUX_BIT  = 2;

    typedef struct packed {
        logic [1:0] op_mode;
        logic       single_lane;
        logic       dcs_en;
        logic       twos_comp;
        logic       aux_ctl;
        logic [1:0] rsvd;
    } ctrl_fields_t;

endpackage

// File: rtl/cfgspi_link_rx.sv
module cfgspi_link_rx #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int FRAME_LEN = 16,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    output logic              sel_o,
    output logic              fall_o,
    output logic              hdr_vld_o,
    output logic              hdr_rw_o,
    output logic [ADDR_W-1:0] hdr_addr_o,
    output logic              frame_ok_o,
    output logic              frame_rw_o,
    output logic [ADDR_W-1:0] frame_addr_o,
    output logic [DATA_W-1:0] frame_data_o
);

    localparam int HDR_LEN = FRAME_LEN - DATA_W;
    localparam int CNT_W   = $clog2(FRAME_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_LEN - 1);

    typedef struct packed {
        logic [SYNC_LEN-1:0]  sclk_sy;
        logic [SYNC_LEN-1:0]  csn_sy;
        logic [SYNC_LEN-1:0]  sdi_sy;
        logic                 sclk_prev;
        logic                 sel_prev;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] sh;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic sclk_s, sdi_s, sel_s, rise_s;

    always_comb begin
        st_d   = st_q;
        sclk_s = st_q.sclk_sy[SYNC_LEN-1];
        sdi_s  = st_q.sdi_sy[SYNC_LEN-1];
        sel_s  = ~st_q.csn_sy[SYNC_LEN-1];

        st_d.sclk_sy = (st_q.sclk_sy << 1) | SYNC_LEN'(sclk_i);
        st_d.csn_sy  = (st_q.csn_sy  << 1) | SYNC_LEN'(csn_i);
        st_d.sdi_sy  = (st_q.sdi_sy  << 1) | SYNC_LEN'(sdi_i);

        rise_s = sel_s &  sclk_s & ~st_q.sclk_prev;
        fall_o = sel_s & ~sclk_s &  st_q.sclk_prev;

        st_d.sclk_prev = sclk_s;
        st_d.sel_prev  = sel_s;

        if (!sel_s) begin
            st_d.cnt = '0;
        end else if (rise_s) begin
            st_d.sh = {st_q.sh[FRAME_LEN-2:0], sdi_s};
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        sel_o        = sel_s;
        hdr_vld_o    = rise_s && (st_q.cnt == CNT_HDR);
        hdr_rw_o     = st_q.sh[HDR_LEN-2];
        hdr_addr_o   = {st_q.sh[ADDR_W-2:0], sdi_s};
        frame_ok_o   = ~sel_s && st_q.sel_prev && (st_q.cnt == CNT_FULL);
        frame_rw_o   = st_q.sh[FRAME_LEN-1];
        frame_addr_o = st_q.sh[DATA_W+ADDR_W-1:DATA_W];
        frame_data_o = st_q.sh[DATA_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.csn_sy <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the header is complete after exactly HDR_LEN rising edges
    p_hdr_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hdr_vld_o |=> (st_q.cnt == CNT_W'(HDR_LEN)));

    // R4: the counter restarts from zero for every new selection
    p_cnt_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_o) |-> (st_q.cnt == '0));

endmodule

// File: rtl/cfgspi_rd_tx.sv
module cfgspi_rd_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic              bit_o
);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              live;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sel_i) begin
            st_d.sh   = '0;
            st_d.live = 1'b0;
        end else if (load_i) begin
            st_d.sh   = load_data_i;
            st_d.live = 1'b0;
        end else if (fall_i) begin
            if (st_q.live) begin
                st_d.sh = st_q.sh << 1;
            end
            st_d.live = 1'b1;
        end
        bit_o = st_q.live & st_q.sh[DATA_W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: each falling edge during the data byte moves the next bit up
    p_shift_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && fall_i && !load_i && st_q.live) |=> (st_q.sh == ($past(st_q.sh) << 1)));

endmodule

// File: rtl/cfgspi_reg_bank.sv
module cfgspi_reg_bank #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int IMPL_REGS = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           waddr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [ADDR_W-1:0]           raddr_i,
    output logic [DATA_W-1:0]           rdata_o,
    output logic [IMPL_REGS*DATA_W-1:0] regs_o
);

    typedef struct packed {
        logic [IMPL_REGS-1:0][DATA_W-1:0] regs;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int i = 0; i < IMPL_REGS; i++) begin
            if (we_i && (waddr_i == ADDR_W'(i))) begin
                st_d.regs[i] = wdata_i;
            end
            if (raddr_i == ADDR_W'(i)) begin
                rdata_o = st_q.regs[i];
            end
        end
        regs_o = st_q.regs;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < IMPL_REGS; g++) begin : g_chk
        // R3: a commit lands in the addressed entry one cycle later
        p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && (waddr_i == ADDR_W'(g))) |=> (st_q.regs[g] == $past(wdata_i)));
        // R5: entries without a commit keep their value
        p_entry_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(we_i && (waddr_i == ADDR_W'(g))) |=> $stable(st_q.regs[g]));
    end

endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
    import cfgspi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [1:0]        op_mode_o,
    output logic              single_lane_o,
    output logic              dcs_en_o,
    output logic              twos_comp_o,
    output logic              aux_ctl_o,
    output logic [1:0]        ctrl_rsvd_o,
    output logic [DATA_W-1:0] pattern_a_o,
    output logic [DATA_W-1:0] pattern_b_o
);

    logic              sel_s, fall_s, hdr_vld_s, hdr_rw_s;
    logic [ADDR_W-1:0] hdr_addr_s;
    logic              frame_ok_s, frame_rw_s;
    logic [ADDR_W-1:0] frame_addr_s;
    logic [DATA_W-1:0] frame_data_s;
    logic              we_s, load_s, tx_bit_s;
    logic [DATA_W-1:0] rdata_s;
    logic [IMPL_REGS*DATA_W-1:0] regs_s;
    logic [DATA_W-1:0] ctrl_byte_s;
    ctrl_fields_t      ctrl_s;

    cfgspi_link_rx #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FRAME_LEN(FRAME_LEN),
        .SYNC_LEN (SYNC_LEN)
    ) i_link (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sclk_i       (sclk_i),
        .csn_i        (csn_i),
        .sdi_i        (sdi_i),
        .sel_o        (sel_s),
        .fall_o       (fall_s),
        .hdr_vld_o    (hdr_vld_s),
        .hdr_rw_o     (hdr_rw_s),
        .hdr_addr_o   (hdr_addr_s),
        .frame_ok_o   (frame_ok_s),
        .frame_rw_o   (frame_rw_s),
        .frame_addr_o (frame_addr_s),
        .frame_data_o (frame_data_s)
    );

    always_comb begin
        we_s   = frame_ok_s & ~frame_rw_s;
        load_s = hdr_vld_s & hdr_rw_s;
    end

    cfgspi_reg_bank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IMPL_REGS(IMPL_REGS)
    ) i_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_s),
        .waddr_i (frame_addr_s),
        .wdata_i (frame_data_s),
        .raddr_i (hdr_addr_s),
        .rdata_o (rdata_s),
        .regs_o  (regs_s)
    );

    cfgspi_rd_tx #(
        .DATA_W(DATA_W)
    ) i_tx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_i       (sel_s),
        .fall_i      (fall_s),
        .load_i      (load_s),
        .load_data_i (rdata_s),
        .bit_o       (tx_bit_s)
    );

    always_comb begin
        ctrl_byte_s        = regs_s[DATA_W-1:0];
        ctrl_s.op_mode     = ctrl_byte_s[MODE_LSB+1:MODE_LSB];
        ctrl_s.single_lane = ctrl_byte_s[LANE_BIT];
        ctrl_s.dcs_en      = ctrl_byte_s[DCS_BIT];
        ctrl_s.twos_comp   = ctrl_byte_s[FMT_BIT];
        ctrl_s.aux_ctl     = ctrl_byte_s[AUX_BIT];
        ctrl_s.rsvd        = ctrl_byte_s[1:0];

        op_mode_o     = ctrl_s.op_mode;
        single_lane_o = ctrl_s.single_lane;
        dcs_en_o      = ctrl_s.dcs_en;
        twos_comp_o   = ctrl_s.twos_comp;
        aux_ctl_o     = ctrl_s.aux_ctl;
        ctrl_rsvd_o   = ctrl_s.rsvd;
        pattern_a_o   = regs_s[2*DATA_W-1:DATA_W];
        pattern_b_o   = regs_s[3*DATA_W-1:2*DATA_W];

        sdo_oe_o = sel_s;
        sdo_o    = sel_s & tx_bit_s;
    end

    // R3: a commit only follows the cycle in which the select was released
    p_commit_on_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_s |-> (!sel_s && $past(sel_s)));

    // R7: the first driven bit of a frame is zero
    p_first_bit_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sdo_oe_o) |-> (sdo_o == 1'b0));

endmodule

// File: tb/test_cfgspi_slave.sv
`timescale 1ns/1ps
module test_cfgspi_slave;

    localparam int HALF = 8;
    localparam int NVEC = 14;
    // {frame word, expected byte on the serial output during the second byte}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h00A5_00, 24'h8000_A5, 24'h013C_00, 24'h02C3_00,
        24'h81FF_3C, 24'h8200_C3, 24'h0577_00, 24'h8500_00,
        24'h705A_00, 24'h8000_5A, 24'h8F00_00, 24'h00FC_00,
        24'h8000_FC, 24'h8100_3C
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, single_lane, dcs_en, twos_comp, aux_ctl;
    logic [1:0] op_mode, ctrl_rsvd;
    logic [7:0] pattern_a, pattern_b;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [7:0] mdl [3];

    always #2.5 clk = ~clk;

    cfgspi_slave i_cfgspi_slave (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sclk_i       (sclk),
        .csn_i        (csn),
        .sdi_i        (sdi),
        .sdo_o        (sdo),
        .sdo_oe_o     (sdo_oe),
        .op_mode_o    (op_mode),
        .single_lane_o(single_lane),
        .dcs_en_o     (dcs_en),
        .twos_comp_o  (twos_comp),
        .aux_ctl_o    (aux_ctl),
        .ctrl_rsvd_o  (ctrl_rsvd),
        .pattern_a_o  (pattern_a),
        .pattern_b_o  (pattern_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_apply(input logic [15:0] w);
        if (!w[15] && (w[11:8] < 4'd3)) mdl[w[11:8]] = w[7:0];
    endtask

    task automatic check_outputs(input string req);
        check({req, " ctrl"}, {24'h0, op_mode, single_lane, dcs_en, twos_comp, aux_ctl, ctrl_rsvd}, {24'h0, mdl[0]});
        check({req, " patterns"}, {16'h0, pattern_a, pattern_b}, {16'h0, mdl[1], mdl[2]});
    endtask

    // drives one frame of nclk serial clocks; returns the two sampled output bytes
    task automatic frame(input logic [15:0] w, input int nclk, input bit rel,
                         output logic [7:0] rd, output logic [7:0] fb, output logic oe_bad);
        rd = '0; fb = '0; oe_bad = 1'b0;
        csn = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(HALF);
            if (!sdo_oe) oe_bad = 1'b1;
            if (i < 8) fb[7-i] = sdo;
            else if (i < 16) rd[15-i] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        if (rel) begin
            csn = 1'b1;
            wait_clk(10);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_err++;
                n_chk++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rd, fb;
        logic oe_bad;
        for (int k = 0; k < 3; k++) mdl[k] = '0;

        wait_clk(5);
        check("R1 reset oe", {31'h0, sdo_oe}, 32'h0);
        check_outputs("R1 reset");
        rst_n = 1'b1;
        wait_clk(5);

        // table walk: R2 R5 R6 R7 R8 R9 R10 R11
        for (int v = 0; v < NVEC; v++) begin
            frame(VEC[v][23:8], 16, 1'b1, rd, fb, oe_bad);
            model_apply(VEC[v][23:8]);
            check(VEC[v][23] ? "R6 read byte" : "R7 write second byte", {24'h0, rd}, {24'h0, VEC[v][7:0]});
            check("R7 first byte", {24'h0, fb}, 32'h0);
            check("R7 oe in frame", {31'h0, oe_bad}, 32'h0);
            check("R7 oe after release", {31'h0, sdo_oe}, 32'h0);
            check_outputs(VEC[v][23] ? "R5 R9 R10" : "R2 R8 R9 R10");
        end

        // R3: commit waits for release
        frame(16'h0199, 16, 1'b0, rd, fb, oe_bad);
        wait_clk(12);
        check("R3 held before release", {24'h0, pattern_a}, {24'h0, mdl[1]});
        csn = 1'b1;
        wait_clk(10);
        model_apply(16'h0199);
        check("R3 after release", {24'h0, pattern_a}, 32'h99);

        // R4: short and long frames write nothing
        frame(16'h0211, 12, 1'b1, rd, fb, oe_bad);
        check("R4 short 12", {24'h0, pattern_b}, {24'h0, mdl[2]});
        frame(16'h0244, 15, 1'b1, rd, fb, oe_bad);
        check("R4 short 15", {24'h0, pattern_b}, {24'h0, mdl[2]});
        frame(16'h0222, 17, 1'b1, rd, fb, oe_bad);
        check("R4 long 17", {24'h0, pattern_b}, {24'h0, mdl[2]});
        frame(16'h8200, 16, 1'b1, rd, fb, oe_bad);
        check("R4 readback", {24'h0, rd}, {24'h0, mdl[2]});

        // R9: each field of register 0 alone
        frame(16'h0040, 16, 1'b1, rd, fb, oe_bad); model_apply(16'h0040);
        check("R9 mode 01", {30'h0, op_mode}, 32'h1);
        frame(16'h0020, 16, 1'b1, rd, fb, oe_bad); model_apply(16'h0020);
        check("R9 lane", {31'h0, single_lane}, 32'h1);
        frame(16'h0014, 16, 1'b1, rd, fb, oe_bad); model_apply(16'h0014);
        check("R9 dcs+aux", {30'h0, dcs_en, aux_ctl}, 32'h3);
        frame(16'h000B, 16, 1'b1, rd, fb, oe_bad); model_apply(16'h000B);
        check("R9 fmt+rsvd", {29'h0, twos_comp, ctrl_rsvd}, 32'h7);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        wait_clk(3);
        for (int k = 0; k < 3; k++) mdl[k] = '0;
        check_outputs("R1 second reset");
        rst_n = 1'b1;
        wait_clk(5);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule